// File: doc/BRIEF.md
# Converter Host Register Block

This block sits between a byte-wide host I/O bus and a 12-bit successive-approximation converter. It decodes a window of 16 byte addresses and holds the configuration: a 4-bit input channel number, a 3-bit amplifier gain code and a mode byte. The mode byte picks the conversion trigger and enables the interrupt and the DMA request. A conversion starts from one of three sources: a host write, a pulse from an internal pacer, or an external pulse pin. The block then waits for the converter's done strobe, latches the 12-bit result and drops an active-low ready flag. It also raises an interrupt and pulses a DMA request when those are enabled.

The host reads the result as two bytes. It reads the upper byte first, which carries the top nibble and the ready flag. It then reads the lower byte, which closes the result and sets the flag high again. The converter side is a plain start/busy/done handshake with no back-pressure. A start is a single-cycle pulse. The block never issues a second start until it has seen done, and it ignores triggers while the converter reports busy. Host register accesses complete in one cycle and cannot be stalled.

Top module: `adc_host_regs`

## Requirements
- R1: After reset the channel and gain outputs are 0, `irq` and `dma_req` are 0, the triggers are disabled (a write to offset 12 starts nothing), and a read of offset 5 returns 0x10 while a read of offset 4 returns 0x00.
- R2: A write to offset 10 loads bits 3..0 of the write data into `chan_sel` on the next clock edge. Upper data bits are dropped. A write to an unused offset (for example 13) changes neither `chan_sel` nor `gain_sel`.
- R3: A write to offset 9 loads bits 2..0 into `gain_sel`. `gain_bad` is 1 exactly when the code is 5, 6 or 7. Codes 0..4 stand for gains 1, 2, 4, 8 and 16.
- R4: Offset 11 bits 1..0 choose the trigger: 00 none, 01 host write, 10 pacer, 11 external. In mode 01 any write to offset 12 produces one single-cycle `conv_start` pulse.
- R5: In mode 10 a `pacer_pulse` starts a conversion. In mode 11 a rising edge on `ext_trig`, passed through two synchroniser flops, starts one. A level held high starts nothing further. A source that is not selected starts nothing.
- R6: A trigger that arrives while `conv_busy` is high, or while a started conversion has not yet returned `conv_done`, is ignored.
- R7: A read of offset 4 returns result bits 7..0. A read of offset 5 returns result bits 11..8 in bits 3..0, the ready flag in bit 4, and 0 in bits 7..5.
- R8: The ready flag (offset 5 bit 4) is 1 while no result is pending. It goes to 0 on the edge that sees `conv_done`. Reading offset 4 sets it back to 1. Reading offset 5 leaves it unchanged.
- R9: When offset 11 bit 2 is set, `conv_done` sets `irq`, which stays high until any write to offset 8. With bit 2 clear, `irq` stays low.
- R10: When offset 11 bit 3 is set, `dma_req` is high for exactly the one cycle after `conv_done`. With bit 3 clear it stays low.
- R11: When `conv_done` coincides with a read of offset 4, the new result is kept and the ready flag stays 0. When it coincides with a write to offset 8 and the interrupt is enabled, `irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| chan_sel | output | 4 | Selected input channel |
| gain_sel | output | 3 | Amplifier gain code |
| gain_bad | output | 1 | Gain code outside 0..4 |
| pacer_pulse | input | 1 | Single-cycle pacer tick |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | Single-cycle conversion start |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | Single-cycle completion strobe |
| conv_data | input | 12 | Result, valid with `conv_done` |
| irq | output | 1 | Conversion-complete interrupt request |
| dma_req | output | 1 | One-cycle DMA request per result |

## Verification
Two pairs of functions can land in the same cycle. A completion can meet the host's low-byte read, and a completion can meet the host's interrupt-clear write. The bench forces each pair by raising `conv_done` in the same cycle as the bus strobe. For the read pair it judges the outcome by reading offset 5 afterwards: the flag must read 0 and the new upper nibble must be there. For the clear pair it samples `irq` afterwards and expects it to be set. Triggers raised while the converter reports busy are also overlapped on purpose, and the bench checks that the start count does not move.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 12;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 3;
  localparam int CFG_W  = 4;

  // byte offsets inside the 16-location window
  localparam int OFF_LO   = 4;
  localparam int OFF_HI   = 5;
  localparam int OFF_ICLR = 8;
  localparam int OFF_GAIN = 9;
  localparam int OFF_CHAN = 10;
  localparam int OFF_MODE = 11;
  localparam int OFF_SWT  = 12;

  localparam int GAIN_TOP = 4;

  // indices into the write-hit vector
  localparam int NUM_WR  = 5;
  localparam int WR_ICLR = 0;
  localparam int WR_GAIN = 1;
  localparam int WR_CHAN = 2;
  localparam int WR_MODE = 3;
  localparam int WR_SWT  = 4;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_SOFT  = 2'b01,
    SRC_PACER = 2'b10,
    SRC_EXT   = 2'b11
  } trig_src_e;

  typedef struct packed {
    logic      dma_en;
    logic      irq_en;
    trig_src_e src;
  } mode_t;
endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode
  import adc_host_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NUM_WR-1:0] wr_hit,
  output logic              rd_lo,
  output logic              rd_hi
);
  localparam int WR_OFF [NUM_WR] = '{OFF_ICLR, OFF_GAIN, OFF_CHAN, OFF_MODE, OFF_SWT};

  for (genvar k = 0; k < NUM_WR; k++) begin : g_wr
    assign wr_hit[k] = wr && (addr == AW'(WR_OFF[k]));
  end

  assign rd_lo = rd && (addr == AW'(OFF_LO));
  assign rd_hi = rd && (addr == AW'(OFF_HI));
endmodule

// File: rtl/adc_cfg_regs.sv
module adc_cfg_regs
  import adc_host_pkg::*;
#(
  parameter int CW  = CFG_W,
  parameter int CHW = CHAN_W,
  parameter int GW  = GAIN_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_chan,
  input  logic           wr_gain,
  input  logic           wr_mode,
  input  logic [CW-1:0]  wdata,
  output logic [CHW-1:0] chan,
  output logic [GW-1:0]  gain,
  output logic           gain_bad,
  output mode_t          mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan <= '0;
      gain <= '0;
      mode <= '{dma_en: 1'b0, irq_en: 1'b0, src: SRC_NONE};
    end else begin
      if (wr_chan) chan <= wdata[CHW-1:0];
      if (wr_gain) gain <= wdata[GW-1:0];
      if (wr_mode) mode <= mode_t'(wdata[$bits(mode_t)-1:0]);
    end
  end

  assign gain_bad = (gain > GW'(GAIN_TOP));
endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate
  import adc_host_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_e src,
  input  logic      sw_hit,
  input  logic      pacer_pulse,
  input  logic      ext_trig,
  input  logic      conv_busy,
  input  logic      conv_done,
  output logic      conv_start
);
  logic [SYNC:0] sh;
  logic          ext_rise;
  logic          req;
  logic          fire;
  logic          in_flight;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], ext_trig};
  end

  assign ext_rise = sh[SYNC-1] & ~sh[SYNC];

  always_comb begin
    unique case (src)
      SRC_SOFT:  req = sw_hit;
      SRC_PACER: req = pacer_pulse;
      SRC_EXT:   req = ext_rise;
      default:   req = 1'b0;
    endcase
  end

  assign fire = req && !in_flight && !conv_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      in_flight  <= 1'b0;
    end else begin
      conv_start <= fire;
      if (fire)           in_flight <= 1'b1;
      else if (conv_done) in_flight <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
  import adc_host_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int RW = RES_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic          irq_clr,
  input  logic          irq_en,
  input  logic          dma_en,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          dma_req,
  output logic          rdy_n
);
  localparam int HI_W = RW - DW;

  logic [RW-1:0] res;
  logic [DW-1:0] hi_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res     <= '0;
      rdy_n   <= 1'b1;
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      // completion outranks the re-arm and the clear
      if (conv_done) begin
        res   <= conv_data;
        rdy_n <= 1'b0;
      end else if (rd_lo) begin
        rdy_n <= 1'b1;
      end
      if (conv_done && irq_en) irq <= 1'b1;
      else if (irq_clr)        irq <= 1'b0;
      dma_req <= conv_done && dma_en;
    end
  end

  always_comb begin
    hi_byte             = '0;
    hi_byte[HI_W-1:0]   = res[RW-1:DW];
    hi_byte[HI_W]       = rdy_n;
  end

  always_comb begin
    if (rd_lo)      rdata = res[DW-1:0];
    else if (rd_hi) rdata = hi_byte;
    else            rdata = '0;
  end
endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
  import adc_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [CHAN_W-1:0] chan_sel,
  output logic [GAIN_W-1:0] gain_sel,
  output logic              gain_bad,
  input  logic              pacer_pulse,
  input  logic              ext_trig,
  output logic              conv_start,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq,
  output logic              dma_req
);
  logic [NUM_WR-1:0] wr_hit;
  logic              rd_lo;
  logic              rd_hi;
  mode_t             mode;
  logic              irq_en;
  logic              rdy_n;

  adc_addr_decode #(.AW(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_hit (wr_hit),
    .rd_lo  (rd_lo),
    .rd_hi  (rd_hi)
  );

  adc_cfg_regs #(.CW(CFG_W), .CHW(CHAN_W), .GW(GAIN_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_chan  (wr_hit[WR_CHAN]),
    .wr_gain  (wr_hit[WR_GAIN]),
    .wr_mode  (wr_hit[WR_MODE]),
    .wdata    (bus_wdata[CFG_W-1:0]),
    .chan     (chan_sel),
    .gain     (gain_sel),
    .gain_bad (gain_bad),
    .mode     (mode)
  );

  assign irq_en = mode.irq_en;

  adc_trig_gate #(.SYNC(2)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .src         (mode.src),
    .sw_hit      (wr_hit[WR_SWT]),
    .pacer_pulse (pacer_pulse),
    .ext_trig    (ext_trig),
    .conv_busy   (conv_busy),
    .conv_done   (conv_done),
    .conv_start  (conv_start)
  );

  adc_result_hold #(.DW(BYTE_W), .RW(RES_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .irq_clr   (wr_hit[WR_ICLR]),
    .irq_en    (irq_en),
    .dma_en    (mode.dma_en),
    .rdata     (bus_rdata),
    .irq       (irq),
    .dma_req   (dma_req),
    .rdy_n     (rdy_n)
  );
endmodule

// File: rtl/adc_host_regs_chk.sv
module adc_host_regs_chk
  import adc_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              conv_start,
  input logic              conv_busy,
  input logic              conv_done,
  input logic              irq,
  input logic              dma_req,
  input logic              irq_en,
  input logic              rdy_n
);
  // R4
  conv_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R6
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !conv_start);

  // R8
  done_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !rdy_n);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && irq_en) |=> irq);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_ICLR) && !conv_done) |=> !irq);

  // R10
  dma_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(conv_done));
endmodule

bind adc_host_regs adc_host_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .conv_start (conv_start),
  .conv_busy  (conv_busy),
  .conv_done  (conv_done),
  .irq        (irq),
  .dma_req    (dma_req),
  .irq_en     (irq_en),
  .rdy_n      (rdy_n)
);

// File: tb/test_adc_host_regs.sv
module test_adc_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  chan_sel;
  logic [2:0]  gain_sel;
  logic        gain_bad;
  logic        pacer_pulse = 1'b0;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic        conv_busy = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        irq;
  logic        dma_req;

  int n_chk = 0;
  int n_bad = 0;
  int n_starts = 0;

  always #5 clk = ~clk;

  adc_host_regs i_adc_host_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .chan_sel, .gain_sel, .gain_bad, .pacer_pulse, .ext_trig, .conv_start,
    .conv_busy, .conv_done, .conv_data, .irq, .dma_req
  );

  always @(posedge clk) if (rst_n && conv_start) n_starts++;

  // {addr, data, expected chan, expected gain, expected gain_bad}
  localparam logic [19:0] VEC [8] = '{
    {4'd10, 8'h37, 4'h7, 3'd0, 1'b0},
    {4'd9,  8'h03, 4'h7, 3'd3, 1'b0},
    {4'd9,  8'hFC, 4'h7, 3'd4, 1'b0},
    {4'd9,  8'h05, 4'h7, 3'd5, 1'b1},
    {4'd10, 8'hAF, 4'hF, 3'd5, 1'b1},
    {4'd9,  8'h07, 4'hF, 3'd7, 1'b1},
    {4'd9,  8'h00, 4'hF, 3'd0, 1'b0},
    {4'd13, 8'h55, 4'hF, 3'd0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic complete(input logic [11:0] d);
    @(negedge clk);
    conv_busy = 1'b0; conv_data = d; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pace();
    @(negedge clk); pacer_pulse = 1'b1;
    @(negedge clk); pacer_pulse = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 chan", chan_sel, 0);
    chk("R1 gain", gain_sel, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", dma_req, 0);
    rd(4'd5, r); chk("R1 hi byte", r, 8'h10);
    rd(4'd4, r); chk("R1 lo byte", r, 8'h00);
    wr(4'd12, 8'h00); idle(2);
    chk("R1 disabled start", n_starts, 0);

    // R2 R3 table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      chk("R2 chan", chan_sel, VEC[i][7:4]);
      chk("R3 gain", gain_sel, VEC[i][3:1]);
      chk("R3 gain_bad", gain_bad, VEC[i][0]);
    end

    // R4 software trigger
    wr(4'd11, 8'h01);
    wr(4'd12, 8'hA5); idle(2);
    chk("R4 sw start", n_starts, 1);
    complete(12'hA5C);
    chk("R9 irq off", irq, 0);
    chk("R10 dma off", dma_req, 0);
    rd(4'd5, r); chk("R7 hi", r, 8'h0A);
    rd(4'd5, r); chk("R8 hi read keeps flag", r, 8'h0A);
    rd(4'd4, r); chk("R7 lo", r, 8'h5C);
    rd(4'd5, r); chk("R8 flag rearmed", r, 8'h1A);

    // R5 pacer not selected
    pace(); idle(2);
    chk("R5 pacer unselected", n_starts, 1);

    // R5 pacer selected, R6 busy
    wr(4'd11, 8'h06);
    pace(); idle(2);
    chk("R5 pacer start", n_starts, 2);
    @(negedge clk) conv_busy = 1'b1;
    pace(); idle(2);
    chk("R6 pacer while busy", n_starts, 2);
    complete(12'h3E1);
    chk("R9 irq set", irq, 1);
    wr(4'd8, 8'h00);
    chk("R9 irq cleared", irq, 0);

    // R5 external edge, R10 dma
    wr(4'd11, 8'h0B);
    @(negedge clk) ext_trig = 1'b1;
    idle(6);
    chk("R5 ext start", n_starts, 3);
    complete(12'h123);
    chk("R10 dma pulse", dma_req, 1);
    idle(1);
    chk("R10 dma single", dma_req, 0);
    chk("R9 irq disabled", irq, 0);
    idle(6);
    chk("R5 ext level", n_starts, 3);
    @(negedge clk) ext_trig = 1'b0;
    idle(4);

    // R11 completion with low-byte read
    wr(4'd11, 8'h05);
    wr(4'd12, 8'h00); idle(2);
    chk("R4 sw start again", n_starts, 4);
    wr(4'd12, 8'h00); idle(2);
    chk("R6 in flight", n_starts, 4);
    @(negedge clk);
    conv_data = 12'h9B7; conv_done = 1'b1; bus_addr = 4'd4; bus_rd = 1'b1;
    #1 chk("R11 old lo", bus_rdata, 8'h23);
    @(negedge clk);
    conv_done = 1'b0; bus_rd = 1'b0;
    rd(4'd5, r); chk("R11 flag kept", r, 8'h09);
    rd(4'd4, r); chk("R11 new lo", r, 8'hB7);

    // R11 completion with interrupt clear
    wr(4'd8, 8'h00);
    chk("R9 clear", irq, 0);
    wr(4'd12, 8'h00); idle(2);
    @(negedge clk);
    conv_data = 12'h456; conv_done = 1'b1;
    bus_addr = 4'd8; bus_wr = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; bus_wr = 1'b0;
    chk("R11 irq wins", irq, 1);
    wr(4'd8, 8'h00);
    chk("R9 final clear", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule